// File: doc/BRIEF.md
# Double-Buffered Timer Compare Unit

This block holds a set of compare channels that watch a free-running time count supplied from outside. Each channel has a control/status word and a compare word. When the count lands on the channel's live compare value, the channel latches an event flag and may raise the shared interrupt. It also drives its output pin in one of two styles: the pin either flips on every event or goes high for a single cycle.

The compare word is double-buffered. While a channel is idle (mode field zero), a compare write sets the live value. Once a mode is running, a compare write only loads a standby slot, and the next event moves that slot into the live position. Software arms a channel by writing the first event time while idle, then setting the mode, then writing the second event time. From then on, each interrupt service writes the event after the next one. This gives a periodic output with no gaps, such as a once-per-second pulse. Compare values are as wide as the time count, 31 bits by default.

Top module: `tcmp_unit`

## Requirements
- R1: Control word layout: bit 7 is the event flag, bit 6 enables the interrupt, bits 5:2 hold the mode, bit 0 (request enable) always reads 0, and all other bits read 0. After reset every control and compare word of every channel reads 0, and all pins and the interrupt are low.
- R2: An event happens when the mode is 0x5 or 0xF, the count is different from its value on the previous cycle, and the count equals the live compare value. The flag reads 1 from the cycle after the event. Writing 1 to bit 7 clears the flag and writing 0 to bit 7 leaves it unchanged. An event in the same cycle as a clearing write keeps the flag set.
- R3: In mode 0x5 the pin inverts once on each event and otherwise holds its level.
- R4: In mode 0xF the pin is high for exactly the one cycle after an event and is low otherwise.
- R5: A compare write while the mode field is zero sets the live value. A compare write while the mode field is nonzero fills the standby slot. Compare reads return the live value, masked to the count width, so writing all ones reads back 0x7FFFFFFF.
- R6: On an event with a filled standby slot, the standby value becomes live and the slot empties.
- R7: On an event with an empty standby slot, the live value is kept, and a new event occurs each time the count reaches that value again.
- R8: The interrupt is high exactly when some channel has both its flag and its interrupt enable set.
- R9: A control write with mode field zero, including an all-zero write, stops events, drives the pin low, and discards any value in the standby slot.
- R10: Mode values other than 0x5 and 0xF produce no events, no flag and no pin activity.
- R11: Channel n has its control word at byte offset 8n and its compare word at 8n+4. A write or event on one channel leaves every other channel's pin and registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CW | Current time count |
| wr_en | input | 1 | Register write strobe |
| addr | input | CH_W+1 | Byte address bits [CH_W+2:2]; bit 2 selects the compare word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pins | output | NCH | Per-channel output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are the ones that need a register write and an event in the same clock edge: a flag clear racing an event, and the standby slot being consumed before a new value lands. The bench drives the time count directly, one value per cycle, so it can place the count on a compare value in exactly the cycle it chooses and line up a control write with that edge. The count can also be held still or sent backwards to show that no event repeats without count movement, and that a retained live value fires again after the count wraps.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int REG_W    = 32;
    localparam int FLAG_POS = 7;
    localparam int IE_POS   = 6;
    localparam int MODE_POS = 2;
    localparam int MODE_W   = 4;

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
    localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;

    typedef struct packed {
        logic              flag;
        logic              ie;
        logic [MODE_W-1:0] mode;
    } ctl_t;

    // True for the two mode codes that generate events
    function automatic logic mode_live(input logic [MODE_W-1:0] m);
        return (m == MODE_TOGGLE) || (m == MODE_PULSE);
    endfunction

    // Build the readable control word; request-enable and spare bits are zero
    function automatic logic [REG_W-1:0] ctl_word(input ctl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[FLAG_POS]              = c.flag;
        w[IE_POS]                = c.ie;
        w[MODE_POS +: MODE_W]    = c.mode;
        return w;
    endfunction

endpackage

// File: rtl/tcmp_addr_dec.sv
module tcmp_addr_dec #(
    parameter  int NCH  = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              wr_en,
    input  logic [CH_W+2:2]   addr,
    output logic [NCH-1:0]    wr_ctrl,
    output logic [NCH-1:0]    wr_cmp,
    output logic [CH_W-1:0]   ch_idx,
    output logic              cmp_sel
);

    assign ch_idx  = addr[CH_W+2:3];
    assign cmp_sel = addr[2];

    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign wr_ctrl[g] = wr_en && !cmp_sel && (ch_idx == CH_W'(g));
        assign wr_cmp[g]  = wr_en &&  cmp_sel && (ch_idx == CH_W'(g));
    end

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
    import tcmp_pkg::*;
#(
    parameter int CW = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    cnt,
    input  logic             cnt_moved,
    input  logic             wr_ctrl,
    input  logic             wr_cmp,
    input  logic [CW-1:0]    wdata,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [REG_W-1:0] cmp_rd,
    output logic             pin,
    output logic             irq_req
);

    ctl_t             ctl;
    logic [CW-1:0]    act;
    logic [CW-1:0]    pre;
    logic             pre_vld;
    logic             pin_q;
    logic             hit;
    logic [MODE_W-1:0] wmode;

    assign wmode = wdata[MODE_POS +: MODE_W];
    assign hit   = mode_live(ctl.mode) && cnt_moved && (cnt == act);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            act     <= '0;
            pre     <= '0;
            pre_vld <= 1'b0;
            pin_q   <= 1'b0;
        end else begin
            // event handling: promote standby, drive pin
            if (hit) begin
                if (pre_vld) begin
                    act     <= pre;
                    pre_vld <= 1'b0;
                end
                if (ctl.mode == MODE_TOGGLE) pin_q <= ~pin_q;
                else                         pin_q <= 1'b1;
            end else if (ctl.mode != MODE_TOGGLE) begin
                pin_q <= 1'b0;
            end

            // flag: event wins over a same-cycle clear
            if (hit)                               ctl.flag <= 1'b1;
            else if (wr_ctrl && wdata[FLAG_POS])   ctl.flag <= 1'b0;

            if (wr_ctrl) begin
                ctl.ie   <= wdata[IE_POS];
                ctl.mode <= wmode;
                if (wmode == MODE_OFF) begin
                    pin_q   <= 1'b0;
                    pre_vld <= 1'b0;
                end
            end

            if (wr_cmp) begin
                if (ctl.mode == MODE_OFF) begin
                    act <= wdata;
                end else begin
                    pre     <= wdata;
                    pre_vld <= 1'b1;
                end
            end
        end
    end

    assign ctrl_rd = ctl_word(ctl);
    assign cmp_rd  = REG_W'(act);
    assign pin     = pin_q;
    assign irq_req = ctl.flag && ctl.ie;

    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctl.flag);                                                  // R2
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[FLAG_POS] && !hit) |=> !ctl.flag);                // R2
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (hit && ctl.mode == MODE_TOGGLE && !wr_ctrl) |=> (pin_q != $past(pin_q))); // R3
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        (pin_q && ctl.mode == MODE_PULSE && !hit && !wr_ctrl) |=> !pin_q);  // R4
    AST_PROMOTE: assert property (@(posedge clk) disable iff (rst)
        (hit && pre_vld) |=> (act == $past(pre)));                          // R6
    AST_RETAIN: assert property (@(posedge clk) disable iff (rst)
        (hit && !pre_vld && !wr_cmp) |=> $stable(act));                     // R7
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wmode == MODE_OFF) |=> (!pin_q && !pre_vld));           // R9

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter  int NCH  = 4,
    parameter  int CW   = 31,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    cnt,
    input  logic             wr_en,
    input  logic [CH_W+2:2]  addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [NCH-1:0]   pins,
    output logic             irq
);

    logic [CW-1:0]    cnt_q;
    logic             cnt_moved;
    logic [NCH-1:0]   wr_ctrl;
    logic [NCH-1:0]   wr_cmp;
    logic [CH_W-1:0]  ch_idx;
    logic             cmp_sel;
    logic [NCH-1:0]   irq_req;
    logic [REG_W-1:0] ctrl_rd [NCH];
    logic [REG_W-1:0] cmp_rd  [NCH];
    logic             unused_top;

    assign unused_top = ^wdata[REG_W-1:CW];

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt;
    end
    assign cnt_moved = (cnt != cnt_q);

    tcmp_addr_dec #(.NCH(NCH)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_ctrl (wr_ctrl),
        .wr_cmp  (wr_cmp),
        .ch_idx  (ch_idx),
        .cmp_sel (cmp_sel)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tcmp_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cnt       (cnt),
            .cnt_moved (cnt_moved),
            .wr_ctrl   (wr_ctrl[g]),
            .wr_cmp    (wr_cmp[g]),
            .wdata     (wdata[CW-1:0]),
            .ctrl_rd   (ctrl_rd[g]),
            .cmp_rd    (cmp_rd[g]),
            .pin       (pins[g]),
            .irq_req   (irq_req[g])
        );
    end

    assign rdata = cmp_sel ? cmp_rd[ch_idx] : ctrl_rd[ch_idx];
    assign irq   = |irq_req;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_ctrl, wr_cmp}));                                       // R11

endmodule

// File: tb/sim_tcmp_unit.sv
module sim_tcmp_unit;

    localparam int NCH = 4;
    localparam int CW  = 31;

    typedef struct packed {
        logic [1:0]  ch;
        logic [3:0]  mode;
        logic        ie;
        logic [30:0] a;
        logic [30:0] b;
    } row_t;

    localparam row_t ROWS [5] = '{
        '{2'd0, 4'h5, 1'b1, 31'd100,        31'd300},
        '{2'd1, 4'hF, 1'b1, 31'h7FFF_FF00,  31'h10},
        '{2'd2, 4'h5, 1'b0, 31'd5000,       31'd7000},
        '{2'd3, 4'hF, 1'b0, 31'd20,         31'd40},
        '{2'd0, 4'hF, 1'b1, 31'h7FFF_FFF0,  31'h7FFF_FFFE}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt = '0;
    logic          wr_en = 1'b0;
    logic [4:2]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NCH-1:0] pins;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tcmp_unit #(.NCH(NCH), .CW(CW)) u0 (
        .clk (clk), .rst (rst), .cnt (cnt), .wr_en (wr_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .pins (pins), .irq (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int ch, input bit is_cmp, input logic [31:0] d);
        addr  = {2'(ch), is_cmp};
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ch, input bit is_cmp, output logic [31:0] d);
        addr = {2'(ch), is_cmp};
        #1;
        d = rdata;
    endtask

    task automatic step(input logic [30:0] v);
        cnt = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cw;
        logic [31:0] ex;
        bit          tog;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            rd(c, 0, v); chk("R1 reset ctrl", v, 0);
            rd(c, 1, v); chk("R1 reset cmp", v, 0);
        end
        chk("R1 reset pins", 32'(pins), 0);
        chk("R1 reset irq", 32'(irq), 0);

        // table walk: arm, promote, retain, repeat, disable
        for (int i = 0; i < 5; i++) begin
            row_t r;
            r   = ROWS[i];
            tog = (r.mode == 4'h5);
            cw  = {24'h0, 1'b1, r.ie, r.mode, 2'b00};
            ex  = {24'h0, 1'b0, r.ie, r.mode, 2'b00};
            wr(r.ch, 0, 32'h0);
            wr(r.ch, 1, 32'(r.a));
            wr(r.ch, 0, cw);
            wr(r.ch, 1, 32'(r.b));
            rd(r.ch, 1, v); chk("R5 live keeps first write", v, 32'(r.a));
            rd(r.ch, 0, v); chk("R1 ctrl readback", v, ex);
            step(r.a - 31'd1);
            rd(r.ch, 0, v); chk("R2 no flag before event", v, ex);
            step(r.a);
            rd(r.ch, 0, v); chk("R2 flag after event", v, ex | 32'h80);
            chk(tog ? "R3 toggle first" : "R4 pulse high", 32'(pins[r.ch]), 1);
            chk("R8 irq follows enable", 32'(irq), 32'(r.ie));
            rd(r.ch, 1, v); chk("R6 standby promoted", v, 32'(r.b));
            chk("R11 other pins quiet", 32'(pins & ~(4'b1 << r.ch)), 0);
            step(r.a + 31'd1);
            chk(tog ? "R3 toggle holds" : "R4 pulse one cycle", 32'(pins[r.ch]), tog ? 1 : 0);
            wr(r.ch, 0, cw);
            rd(r.ch, 0, v); chk("R2 write-one clears", v, ex);
            chk("R8 irq drops", 32'(irq), 0);
            step(r.b);
            rd(r.ch, 0, v); chk("R2 flag second event", v, ex | 32'h80);
            chk(tog ? "R3 toggle back" : "R4 pulse again", 32'(pins[r.ch]), tog ? 0 : 1);
            rd(r.ch, 1, v); chk("R7 live retained", v, 32'(r.b));
            wr(r.ch, 0, cw);
            step(r.b + 31'd3);
            step(r.b);
            rd(r.ch, 0, v); chk("R7 repeat event", v, ex | 32'h80);
            chk("R7 repeat pin", 32'(pins[r.ch]), 1);
            wr(r.ch, 0, 32'h80);
            chk("R9 disable drops pin", 32'(pins[r.ch]), 0);
        end

        // R1 request-enable and spare bits read zero
        wr(1, 0, 32'hFFFF_FF7F);
        rd(1, 0, v); chk("R1 spare bits zero", v, 32'h7C);
        wr(1, 0, 32'h0);
        // R5 compare masking
        wr(1, 1, 32'hFFFF_FFFF);
        rd(1, 1, v); chk("R5 compare masked", v, 32'h7FFF_FFFF);

        // R10 unsupported mode gives no event
        wr(2, 0, 32'h80);
        wr(2, 1, 32'd50);
        wr(2, 0, 32'h4C);
        step(31'd49);
        step(31'd50);
        rd(2, 0, v); chk("R10 no flag", v, 32'h4C);
        chk("R10 no pin", 32'(pins[2]), 0);
        chk("R10 no irq", 32'(irq), 0);
        wr(2, 0, 32'h80);

        // R2 held count gives one event; writing 0 to bit 7 keeps flag
        wr(0, 0, 32'h80);
        wr(0, 1, 32'd60);
        wr(0, 0, 32'h14);
        step(31'd59);
        step(31'd60);
        repeat (3) @(negedge clk);
        chk("R2 held count single event", 32'(pins[0]), 1);
        wr(0, 0, 32'h14);
        rd(0, 0, v); chk("R2 zero write keeps flag", v, 32'h94);

        // R2 event beats same-cycle clear
        wr(0, 0, 32'h80);
        wr(0, 1, 32'd80);
        wr(0, 0, 32'h14);
        step(31'd79);
        cnt = 31'd80;
        wr(0, 0, 32'h94);
        rd(0, 0, v); chk("R2 event wins over clear", v, 32'h94);
        wr(0, 0, 32'h80);

        // R8 interrupt OR across channels
        wr(1, 0, 32'h80); wr(3, 0, 32'h80);
        wr(1, 1, 32'd200); wr(3, 1, 32'd200);
        wr(1, 0, 32'h7C); wr(3, 0, 32'h7C);
        step(31'd199);
        step(31'd200);
        chk("R8 irq two sources", 32'(irq), 1);
        wr(1, 0, 32'hFC);
        chk("R8 irq one source left", 32'(irq), 1);
        wr(3, 0, 32'hFC);
        chk("R8 irq none left", 32'(irq), 0);
        wr(1, 0, 32'h80); wr(3, 0, 32'h80);

        // R9 disable discards standby value
        wr(2, 0, 32'h80);
        wr(2, 1, 32'd400);
        wr(2, 0, 32'h14);
        wr(2, 1, 32'd900);
        wr(2, 0, 32'h0);
        wr(2, 0, 32'h14);
        step(31'd399);
        step(31'd400);
        rd(2, 1, v); chk("R9 standby discarded", v, 32'd400);
        chk("R11 neighbour pins quiet", 32'(pins & 4'b1011), 0);
        wr(2, 0, 32'h80);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule